// File: doc/BRIEF.md
# Asynchronous SRAM Bus Interface Controller

This block connects a synchronous request port to an asynchronous static RAM that has one bidirectional data bus and two active-low strobes, one for writing and one for enabling the RAM's output. A client offers a request with a valid/ready handshake. Each request carries a direction flag, an address and write data. The controller latches the request and plays out the bus timing over a fixed number of clock cycles. It then raises a one-cycle completion pulse. For a read, the captured word is presented on a holding register.

A write has three phases. Address and data are driven with both strobes high (setup). The write strobe is then held low for a programmed width. Finally it is released while address and data stay put (hold). A read also starts with a setup phase. The output strobe is then held low for the access time while the controller leaves the bus undriven, and the bus is sampled on the last access cycle. A turnaround phase follows, with both strobes high and the bus released. Every phase length is a parameter counted in clock cycles.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset both strobes are high, the data bus is not driven, `reqReady` is 1 and `done` is 0.
- R2: A request is taken only in a cycle where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the cycle after acceptance until the completion pulse. A `reqValid` raised while `reqReady` is 0 and dropped before `reqReady` returns has no effect on the memory or on `done`.
- R3: A write (`reqWrite`=1) drives address and data with both strobes high for SETUP_CYC cycles. It then holds `sramWeN` low for STROBE_CYC cycles, and then keeps address and data driven with `sramWeN` high for HOLD_CYC cycles. The word is stored at the address.
- R4: A read (`reqWrite`=0) presents the address for SETUP_CYC cycles and then holds `sramOeN` low for ACCESS_CYC cycles. The controller never drives the bus while `sramOeN` is low. `rdData` takes the bus value sampled at the end of the last cycle with `sramOeN` low.
- R5: `sramWeN` and `sramOeN` are never low in the same cycle.
- R6: In the cycle after `sramOeN` returns high, both strobes are high and the controller does not drive the bus.
- R7: `done` is a one-cycle pulse. It appears SETUP_CYC+STROBE_CYC+HOLD_CYC cycles after the acceptance edge for a write, and SETUP_CYC+ACCESS_CYC+TURN_CYC cycles after it for a read.
- R8: `rdData` holds its value through later writes and changes only when a read completes.
- R9: `reqReady` is 1 in the cycle `done` is 1, so a request offered there is accepted at once. Its own `done` then follows by the latency of R7, counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Last word read |
| sramAddr | output | ADDR_W | Address to the RAM |
| sramWeN | output | 1 | Write strobe, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramData | inout | DATA_W | Shared data bus |

## Verification
Isolated writes followed by reads of the same address show that the strobe widths, the hold and the capture point are right. The bench RAM returns inverted data until the access time has passed, so a capture that comes too early reads the wrong word. Chained requests issued in each completion cycle alternate reads and writes, which exercises turnaround and the exact spacing between completions. A request waved while the controller is busy, followed by a read of its target, shows the handshake is respected. All-ones and all-zero words and the top address probe the data and address extremes.

// File: rtl/sram_bus_ctrl_pkg.sv
package sram_bus_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_ACCESS,
    PH_TURN
  } phase_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic accept;
    logic weN;
    logic oeN;
    logic drive;
    logic capture;
  } busCtl_t;

endpackage

// File: rtl/sram_bus_ctrl_fsm.sv
module sram_bus_ctrl_fsm
  import sram_bus_ctrl_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    done,
  output busCtl_t ctl
);

  localparam int MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B   = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_t            phase, nextPhase;
  logic [CNT_W-1:0]  cnt;
  logic              opWrite;
  logic              lastCycle;

  function automatic logic [CNT_W-1:0] phaseLen(phase_t p);
    case (p)
      PH_SETUP:  return CNT_W'(SETUP_CYC - 1);
      PH_STROBE: return CNT_W'(STROBE_CYC - 1);
      PH_HOLD:   return CNT_W'(HOLD_CYC - 1);
      PH_ACCESS: return CNT_W'(ACCESS_CYC - 1);
      PH_TURN:   return CNT_W'(TURN_CYC - 1);
      default:   return '0;
    endcase
  endfunction

  assign lastCycle = (cnt == '0);
  assign reqReady  = (phase == PH_IDLE);

  always_comb begin
    nextPhase = phase;
    case (phase)
      PH_IDLE:   if (reqValid)  nextPhase = PH_SETUP;
      PH_SETUP:  if (lastCycle) nextPhase = opWrite ? PH_STROBE : PH_ACCESS;
      PH_STROBE: if (lastCycle) nextPhase = PH_HOLD;
      PH_HOLD:   if (lastCycle) nextPhase = PH_IDLE;
      PH_ACCESS: if (lastCycle) nextPhase = PH_TURN;
      PH_TURN:   if (lastCycle) nextPhase = PH_IDLE;
      default:   nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      opWrite <= 1'b0;
      done    <= 1'b0;
    end else begin
      phase <= nextPhase;
      if (nextPhase != phase) cnt <= phaseLen(nextPhase);
      else if (!lastCycle)    cnt <= cnt - 1'b1;
      if (phase == PH_IDLE && reqValid) opWrite <= reqWrite;
      done <= (phase == PH_HOLD || phase == PH_TURN) && lastCycle;
    end
  end

  always_comb begin
    ctl.accept  = (phase == PH_IDLE) && reqValid;
    ctl.weN     = (phase != PH_STROBE);
    ctl.oeN     = (phase != PH_ACCESS);
    ctl.drive   = opWrite && (phase == PH_SETUP || phase == PH_STROBE || phase == PH_HOLD);
    ctl.capture = (phase == PH_ACCESS) && lastCycle;
  end

endmodule

// File: rtl/sram_bus_ctrl_dp.sv
module sram_bus_ctrl_dp
  import sram_bus_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramAddr <= '0;
      busOut   <= '0;
      rdData   <= '0;
    end else begin
      if (ctl.accept) begin
        sramAddr <= reqAddr;
        busOut   <= reqWdata;
      end
      if (ctl.capture) rdData <= busIn;
    end
  end

  assign busDrive = ctl.drive;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramWeN,
  output logic              sramOeN,
  inout  wire  [DATA_W-1:0] sramData
);

  busCtl_t           ctl;
  logic [DATA_W-1:0] busOut;
  logic              busDrive;

  sram_bus_ctrl_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .ACCESS_CYC(ACCESS_CYC),
    .TURN_CYC  (TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .done    (done),
    .ctl     (ctl)
  );

  sram_bus_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .busIn   (sramData),
    .sramAddr(sramAddr),
    .busOut  (busOut),
    .busDrive(busDrive),
    .rdData  (rdData)
  );

  assign sramWeN  = ctl.weN;
  assign sramOeN  = ctl.oeN;
  assign sramData = busDrive ? busOut : 'z;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              done,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              busDrive
);

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramWeN && !sramOeN)); // R5

  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> !busDrive); // R4

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramOeN) |-> (sramWeN && !busDrive)); // R6

  AST_WRITE_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> (busDrive && $past(busDrive) && $stable(sramAddr))); // R3

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (busDrive && $stable(sramAddr))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady); // R9

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .done    (done),
  .sramWeN (sramWeN),
  .sramOeN (sramOeN),
  .sramAddr(sramAddr),
  .busDrive(busDrive)
);

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int S = 1, W = 2, H = 1, A = 2, T = 1;
  localparam int WR_LAT = S + W + H;
  localparam int RD_LAT = S + A + T;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady, done, sramWeN, sramOeN;
  logic [DW-1:0] rdData;
  logic [AW-1:0] sramAddr;
  wire  [DW-1:0] sramData;

  always #5 clk = ~clk;

  sram_bus_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .STROBE_CYC(W),
    .HOLD_CYC(H), .ACCESS_CYC(A), .TURN_CYC(T)
  ) i_sram_bus_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .done(done), .rdData(rdData), .sramAddr(sramAddr),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramData(sramData)
  );

  // behavioural RAM: inverted data until the access time has elapsed
  logic [DW-1:0] mem    [256];
  logic [DW-1:0] shadow [256];
  int            oeAge = 0;
  always @(posedge clk) oeAge <= sramOeN ? 0 : oeAge + 1;
  assign sramData = (!sramOeN && sramWeN)
                  ? ((oeAge >= A - 1) ? mem[sramAddr] : ~mem[sramAddr]) : 'z;
  always @(posedge sramWeN) mem[sramAddr] <= sramData;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit            isWrite;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            acceptCyc;
    bit            chained;
  } item_t;
  item_t q[$];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // driver
  task automatic doOp(input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input bit chained);
    item_t it;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    it.isWrite = w; it.addr = a; it.chained = chained;
    it.data = w ? d : shadow[a];
    if (w) shadow[a] = d;
    it.acceptCyc = cyc + 1;
    q.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor
  int            weRun = 0, oeRun = 0, lastDone = 0;
  logic          prevOeN = 1'b1;
  logic [DW-1:0] lastRd = '0;
  always @(negedge clk) begin
    if (rstN) begin
      check(!( !sramWeN && !sramOeN ), "R5", "both strobes low", {sramWeN, sramOeN}, 2'b11);
      if (!prevOeN && sramOeN)
        check(sramWeN, "R6", "write strobe after read release", sramWeN, 1);
      prevOeN = sramOeN;
      if (!sramWeN) begin
        weRun++;
        if (q.size() != 0)
          check(sramAddr == q[0].addr, "R3", "address under write strobe", sramAddr, q[0].addr);
      end else if (weRun != 0) begin
        check(weRun == W, "R3", "write strobe width", weRun, W);
        weRun = 0;
      end
      if (!sramOeN) oeRun++;
      else if (oeRun != 0) begin
        check(oeRun == A, "R4", "output enable width", oeRun, A);
        oeRun = 0;
      end
      if (done) begin
        if (q.size() == 0) check(0, "R2", "unexpected done", 1, 0);
        else begin
          item_t it;
          int lat;
          it  = q.pop_front();
          lat = it.isWrite ? WR_LAT : RD_LAT;
          check(cyc - it.acceptCyc == lat, "R7", "done latency", cyc - it.acceptCyc, lat);
          if (it.chained)
            check(cyc - lastDone == lat + 1, "R9", "chained spacing", cyc - lastDone, lat + 1);
          if (it.isWrite) begin
            check(mem[it.addr] == it.data, "R3", "stored word", mem[it.addr], it.data);
            check(rdData == lastRd, "R8", "rdData held over write", rdData, lastRd);
          end else begin
            check(rdData == it.data, "R4", "read word", rdData, it.data);
            lastRd = it.data;
          end
        end
        lastDone = cyc;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = DW'(i * 3 + 1);
      shadow[i] = DW'(i * 3 + 1);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1, "R1", "ready after reset", reqReady, 1);
    check(done == 0, "R1", "done after reset", done, 0);
    check(sramWeN == 1 && sramOeN == 1, "R1", "strobes after reset", {sramWeN, sramOeN}, 2'b11);
    repeat (2) @(negedge clk);

    // isolated accesses
    doOp(1, 8'h10, 16'hA5A5, 0); repeat (6) @(negedge clk);
    doOp(0, 8'h10, '0, 0);       repeat (6) @(negedge clk);
    doOp(0, 8'h20, '0, 0);       repeat (6) @(negedge clk);
    doOp(1, 8'hFF, 16'hFFFF, 0); repeat (6) @(negedge clk);
    doOp(1, 8'h00, 16'h0000, 0); repeat (6) @(negedge clk);
    doOp(0, 8'hFF, '0, 0);       repeat (6) @(negedge clk);
    doOp(0, 8'h00, '0, 0);       repeat (6) @(negedge clk);

    // request waved while busy must be ignored (R2)
    doOp(1, 8'h11, 16'h1234, 0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 8'h55; reqWdata = 16'hDEAD;
    @(negedge clk); @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    check(mem[8'h55] == shadow[8'h55], "R2", "busy request left memory alone", mem[8'h55], shadow[8'h55]);
    doOp(0, 8'h55, '0, 0); repeat (6) @(negedge clk);

    // chained, alternating read/write (R6, R9)
    doOp(1, 8'h30, 16'h0F0F, 0);
    for (int i = 0; i < 10; i++) begin
      if (i % 2 == 0) doOp(0, 8'h30 + 8'(i), '0, 1);
      else            doOp(1, 8'h30 + 8'(i + 1), 16'(16'h1111 * i), 1);
    end
    doOp(0, 8'h32, '0, 1);

    for (int k = 0; k < 100 && q.size() != 0; k++) @(negedge clk);
    check(q.size() == 0, "R7", "all requests completed", q.size(), 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule